// File: doc/BRIEF.md
# Dual Reload Down-Counter Timer

This block holds two independent 32-bit down-counters behind a small 32-bit register interface. Software can read and write each counter's current value and its reload value. A single shared control word holds, for each timer, an enable bit and a reload-enable bit. An enabled counter decrements by one on every clock. When an enabled counter sits at zero, the timer has expired. It then either refills from its reload register, which gives periodic operation, or it stops: hardware clears its enable bit and the value stays at zero, which gives one-shot operation.

Each timer drives its own interrupt line, a registered one-cycle pulse per expiry. A typical setup runs one timer with a reload of all ones as a free-running time base. Software reads the inverted value to get an up-count. The other timer serves as an event generator in one-shot or periodic mode.

Top module: `dual_down_timer`

## Requirements
- R1: After reset the control word, both reload registers and both value registers read zero, and both interrupt lines are low.
- R2: The control word sits at offset 0x00. For timer i, bit 2i is the enable and bit 2i+1 is the reload-enable. Bits 4 and above read as zero whatever was written.
- R3: Timer 0 reload is at 0x10 and its value at 0x14. Timer 1 reload is at 0x18 and its value at 0x1C. Any other offset reads zero, and writes to it change no register.
- R4: An enabled counter whose value is non-zero decreases by one on each clock edge. A disabled counter holds its value.
- R5: One-shot mode (value N written, enable set, reload-enable clear). The value reaches zero N edges after the edge that writes the enable. The interrupt is high for exactly one cycle, starting N+1 edges after that write. Hardware then clears the enable bit, and the value stays at zero.
- R6: Periodic mode (reload and value both P, enable and reload-enable set). The first interrupt comes P+1 edges after the enable write, and further ones follow every P+1 edges. With a reload of all ones, the inverted value counts up by one per clock.
- R7: A write to a value register takes effect at that edge and overrides any decrement or reload in the same cycle. Counting then resumes from the written value.
- R8: Each timer has its own interrupt line. Activity on one timer never pulses the other timer's line.
- R9: A timer enabled while its value is already zero expires at once. Its interrupt rises one edge after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each edge is one timer tick |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe for the register interface |
| busAddr | input | 5 | Byte offset of the register accessed |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 2 | Per-timer expiry pulse, bit i for timer i |

## Verification
The bench builds the block with its defaults: two timers of 32 bits each and a 5-bit offset. With these values the real register map and the full-width wrap of an all-ones reload can be exercised. The vector table uses small deltas and periods, including zero and one. This places every expiry, and the second pulse of each periodic run, within a few dozen cycles. The bench can therefore check exact pulse cycles on both lines and confirm that the idle line stays quiet.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  // Per-timer command strobes from control to datapath
  typedef struct packed {
    logic wrValue;   // bus writes the value register
    logic wrReload;  // bus writes the reload register
    logic doReload;  // expiry with reload-enable: refill value
    logic doDec;     // enabled and non-zero: count down
  } tmrStrobe_t;
endpackage

// File: rtl/dual_timer_ctrl.sv
module dual_timer_ctrl
  import dual_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busWe,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic [NUM_TIMERS-1:0]     isZero,
  output tmrStrobe_t [NUM_TIMERS-1:0] strobe,
  output logic [2*NUM_TIMERS-1:0]   ctrlBits,
  output logic [NUM_TIMERS-1:0]     irq
);
  localparam int CTRL_W = 2 * NUM_TIMERS;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]     wordIdx;
  logic                  ctrlWr;
  logic [CTRL_W-1:0]     ctrlQ;
  logic [CTRL_W-1:0]     ctrlNext;
  logic [NUM_TIMERS-1:0] expire;
  logic [NUM_TIMERS-1:0] irqQ;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign ctrlWr  = busWe && (wordIdx == '0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    localparam logic [WORD_W-1:0] RLD_WORD = WORD_W'(4 + 2 * i);
    localparam logic [WORD_W-1:0] VAL_WORD = WORD_W'(5 + 2 * i);
    logic enBit, rlBit, wrVal, wrRld;
    assign enBit     = ctrlQ[2*i];
    assign rlBit     = ctrlQ[2*i+1];
    assign wrVal     = busWe && (wordIdx == VAL_WORD);
    assign wrRld     = busWe && (wordIdx == RLD_WORD);
    assign expire[i] = enBit && isZero[i];
    assign strobe[i] = {wrVal, wrRld,
                        expire[i] && rlBit && !wrVal,
                        enBit && !isZero[i] && !wrVal};

    // R5: one-shot expiry drops the enable unless software rewrites control
    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
      (enBit && isZero[i] && !rlBit && !ctrlWr) |=> !ctrlQ[2*i]);
    // R8: a pulse on this line needs this timer to have been enabled
    p_irq_own_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) |-> $past(ctrlQ[2*i]));
  end

  always_comb begin
    ctrlNext = ctrlQ;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (expire[i] && !ctrlQ[2*i+1]) ctrlNext[2*i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      irqQ  <= '0;
    end else begin
      ctrlQ <= ctrlWr ? busWdata[CTRL_W-1:0] : ctrlNext;
      irqQ  <= expire;
    end
  end

  assign ctrlBits = ctrlQ;
  assign irq      = irqQ;
endmodule

// File: rtl/dual_timer_datapath.sv
module dual_timer_datapath
  import dual_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [DATA_W-1:0]                  wdata,
  input  tmrStrobe_t [NUM_TIMERS-1:0]        strobe,
  output logic [NUM_TIMERS-1:0]              isZero,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0]  valueQ,
  output logic [NUM_TIMERS-1:0][DATA_W-1:0]  reloadQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ  <= '0;
      reloadQ <= '0;
    end else begin
      for (int i = 0; i < NUM_TIMERS; i++) begin
        if (strobe[i].wrReload) reloadQ[i] <= wdata;
        if (strobe[i].wrValue)       valueQ[i] <= wdata;
        else if (strobe[i].doReload) valueQ[i] <= reloadQ[i];
        else if (strobe[i].doDec)    valueQ[i] <= valueQ[i] - DATA_W'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    assign isZero[i] = (valueQ[i] == '0);

    // R4: each decrement strobe lowers the value by exactly one
    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].doDec |=> valueQ[i] == $past(valueQ[i]) - DATA_W'(1));
    // R7: a bus write lands the written word on the next cycle
    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].wrValue |=> valueQ[i] == $past(wdata));
    // R6: a refill copies the reload word held before the edge
    p_refill_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe[i].doReload |=> valueQ[i] == $past(reloadQ[i]));
    // R7: at most one value update source per cycle
    p_one_source_r7: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobe[i].wrValue, strobe[i].doReload, strobe[i].doDec}));
  end
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import dual_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = $clog2(16 + 8 * NUM_TIMERS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CTRL_W = 2 * NUM_TIMERS;

  tmrStrobe_t [NUM_TIMERS-1:0]             strobe;
  logic [NUM_TIMERS-1:0]                   isZero;
  logic [CTRL_W-1:0]                       ctrlBits;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]       valueQ;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]       reloadQ;
  logic [WORD_W-1:0]                       rdWord;

  dual_timer_ctrl #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .isZero(isZero), .strobe(strobe), .ctrlBits(ctrlBits), .irq(irq)
  );

  dual_timer_datapath #(.NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wdata(busWdata), .strobe(strobe),
    .isZero(isZero), .valueQ(valueQ), .reloadQ(reloadQ)
  );

  assign rdWord = busAddr[ADDR_W-1:2];

  always_comb begin
    busRdata = '0;
    if (rdWord == '0) busRdata[CTRL_W-1:0] = ctrlBits;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rdWord == WORD_W'(4 + 2 * i)) busRdata = reloadQ[i];
      if (rdWord == WORD_W'(5 + 2 * i)) busRdata = valueQ[i];
    end
  end
endmodule

// File: tb/dual_down_timer_bench.sv
`timescale 1ns/1ps
module dual_down_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [1:0]  irq;

  int nChecks = 0;
  int nFail   = 0;

  always #2 clk = ~clk;

  dual_down_timer u_dual_down_timer (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // vectors: timer, reload-enable, value/period, first pulse edge
  localparam int NV = 7;
  localparam int VT[NV] = '{0, 1, 0, 1, 1, 0, 0};
  localparam int VR[NV] = '{0, 0, 1, 1, 0, 1, 0};
  localparam int VV[NV] = '{5, 1, 3, 0, 10, 7, 0};
  localparam int VF[NV] = '{6, 2, 4, 1, 11, 8, 1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(5'h00, d); chk("R1 ctrl", d, 0);
    rd(5'h10, d); chk("R1 reload0", d, 0);
    rd(5'h14, d); chk("R1 value0", d, 0);
    rd(5'h18, d); chk("R1 reload1", d, 0);
    rd(5'h1C, d); chk("R1 value1", d, 0);
    chk("R1 irq", {30'd0, irq}, 0);

    // R3: unmapped offsets ignore writes and read zero
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h04, d); chk("R3 unmapped read", d, 0);
    rd(5'h00, d); chk("R3 ctrl untouched", d, 0);
    rd(5'h14, d); chk("R3 value0 untouched", d, 0);

    // R2: upper control bits read zero
    wr(5'h00, 32'hFFFF_FFF0);
    rd(5'h00, d); chk("R2 ctrl upper bits", d, 0);

    // Vector table: one-shot, periodic, per-line separation (R5 R6 R8 R9)
    for (int v = 0; v < NV; v++) begin
      int t, first, second, other;
      t = VT[v];
      wr(5'h00, 0);
      idle(2);
      wr(5'(16 + 8 * t), VV[v]);
      wr(5'(20 + 8 * t), VV[v]);
      wr(5'h00, (32'd1 << (2 * t)) | (32'(VR[v]) << (2 * t + 1)));
      first = -1; second = -1; other = 0;
      for (int k = 1; k <= 60; k++) begin
        @(posedge clk); @(negedge clk);
        if (irq[t]) begin
          if (first < 0) first = k;
          else if (second < 0) second = k;
        end
        if (irq[1 - t]) other = 1;
      end
      chk(VR[v] != 0 ? "R6 first pulse" : (VV[v] == 0 ? "R9 first pulse" : "R5 first pulse"),
          first, VF[v]);
      if (VR[v] != 0) chk("R6 second pulse", second, 2 * VF[v]);
      else            chk("R5 single pulse", second, -1);
      chk("R8 other line quiet", other, 0);
      if (VR[v] == 0) begin
        rd(5'h00, d); chk("R5 enable cleared", d[2*t], 0);
        rd(5'(20 + 8 * t), d); chk("R5 value held at zero", d, 0);
      end
    end

    // R4: counting and holding
    wr(5'h00, 0);
    wr(5'h14, 100);
    wr(5'h00, 1);
    idle(10);
    rd(5'h14, d); chk("R4 decrement", d, 90);
    wr(5'h00, 0);
    idle(10);
    rd(5'h14, d); chk("R4 hold when disabled", d, 89);

    // R7: value write overrides decrement
    wr(5'h00, 1);
    idle(4);
    rd(5'h14, d); chk("R7 before write", d, 85);
    wr(5'h14, 50);
    rd(5'h14, d); chk("R7 write wins", d, 50);
    idle(3);
    rd(5'h14, d); chk("R7 resumes", d, 47);

    // R6: all-ones reload as an up-counting time base
    wr(5'h00, 0);
    wr(5'h10, 32'hFFFF_FFFF);
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h00, 3);
    idle(10);
    rd(5'h14, d); chk("R6 inverted time base", ~d, 10);
    chk("R6 no pulse yet", {30'd0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule